// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the target side of a four-byte serial programming link. A programmer drives a serial clock and a data line into the block and reads a return line from it. While the active-low programming reset input is held low, the block collects 32-bit instructions and decodes them into command strobes for a memory back end. The instructions cover programming enable, chip erase, program-memory page load, page write and read, EEPROM byte write, page load, page write and read, and lock-bit write and read. The back end holds the arrays and page buffers and does the self-timed writes. It answers reads with one cycle of latency and reports a busy flag.

The serial clock and data are brought into the system clock domain through a flop synchronizer, and edges are found there. Data is taken on rising serial-clock edges, and the return line changes after falling ones. The return line echoes the previous byte received, so a programmer can confirm framing by seeing its second byte come back while it sends the third. Read data replaces the echo during the fourth byte.

Top module: `spi_prog_target`

## Requirements
- R1: Every instruction is 32 bits, MSB first. No strobe leaves the block before the 32nd rising serial-clock edge of a frame. Releasing the programming reset clears the bit count, so the next frame starts at bit 31.
- R2: `mosi` is taken on rising serial-clock edges. `miso` changes only after a detected falling edge, never while the serial clock stays high.
- R3: Programming enable is first byte 0xAC and second byte 0x53. The bits on `miso` during byte k+1 are the byte received as byte k, MSB first, except during byte 4 of a read.
- R4: Until a programming enable frame has completed, no `cmd_valid` and no `rd_req` is raised.
- R5: While `prog_rst_n` is high, `miso` is 0, no strobes are raised, and the enable state is lost.
- R6: Chip erase is 0xAC with second-byte bits [7:5] = 100, giving `cmd_op` 1. Lock write is 0xAC with second-byte bits [7:5] = 111 and byte-4 bits [7:6] = 11, giving `cmd_op` 7 with `cmd_data` = byte 4 bits [5:0]. A lock write whose byte-4 bits [7:6] are not 11 is ignored.
- R7: First byte 0x40 or 0x48 is a program page load: `cmd_op` 2, `cmd_hi` = first-byte bit 3, `cmd_addr` = byte-3 bits [3:0], `cmd_data` = byte 4. First byte 0x4C is a program page write: `cmd_op` 3, `cmd_addr` = {byte-2 bit 0, byte-3 bits [7:4], 4'b0}. First byte 0x20 or 0x28 is a program read: `rd_op` 8, `rd_hi` = first-byte bit 3, `rd_addr` = {byte-2 bit 0, byte 3}.
- R8: EEPROM operations take their address from byte 3. 0xC0 is a byte write (`cmd_op` 4, address bits [5:0], data byte 4). 0xC1 is a page load (`cmd_op` 5, address bits [1:0]). 0xC2 is a page write (`cmd_op` 6, address {bits [5:2], 2'b0}). 0xA0 is a read (`rd_op` 9, address bits [5:0]).
- R9: A read raises `rd_req` for one cycle after the 24th bit. The `mem_rdata` of the following cycle is shifted out during byte 4. For a lock read (first byte 0x58, `rd_op` 10, address 0), byte-4 bits [7:6] are forced to 1.
- R10: If `mem_busy` is high when a frame completes, that frame's `cmd_valid` is dropped. Reads are served regardless of `mem_busy`.
- R11: A frame whose first byte matches no instruction raises no strobe.
- R12: `cmd_valid` is high for exactly one system clock per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst_n | input | 1 | Programming mode request, active low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Command code (1..7) |
| cmd_hi | output | 1 | High-byte select for program page loads |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | 8 | Command data |
| rd_req | output | 1 | One-cycle read request |
| rd_op | output | 4 | Read code (8..10) |
| rd_hi | output | 1 | High-byte select for program reads |
| rd_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `rd_req` |
| mem_busy | input | 1 | Back end is completing a self-timed write |

## Verification
The busy flag and a completing frame meet in the same cycle. Whether a strobe appears depends on `mem_busy` at the moment the 32nd bit is decoded, and a read in the same stretch must still be answered. The bench raises `mem_busy` before randomly chosen frames and holds it through frame completion. For each one it predicts that a write-type command disappears and that a read still delivers back-end data in byte 4. It also checks that every strobe that does appear was preceded by a clear busy flag.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

   localparam logic [3:0] OP_NONE      = 4'd0;
   localparam logic [3:0] OP_ERASE     = 4'd1;
   localparam logic [3:0] OP_PM_LOAD   = 4'd2;
   localparam logic [3:0] OP_PM_WRITE  = 4'd3;
   localparam logic [3:0] OP_EE_WRITE  = 4'd4;
   localparam logic [3:0] OP_EE_LOAD   = 4'd5;
   localparam logic [3:0] OP_EE_PGWR   = 4'd6;
   localparam logic [3:0] OP_LOCK_WR   = 4'd7;
   localparam logic [3:0] OP_PM_READ   = 4'd8;
   localparam logic [3:0] OP_EE_READ   = 4'd9;
   localparam logic [3:0] OP_LOCK_RD   = 4'd10;

   localparam logic [7:0] HDR_SYS      = 8'hAC;
   localparam logic [7:0] KEY_ENABLE   = 8'h53;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic is_strobe_op(input logic [3:0] op);
      return (op >= OP_ERASE) && (op <= OP_LOCK_WR);
   endfunction

   function automatic logic is_read_op(input logic [3:0] op);
      return (op >= OP_PM_READ) && (op <= OP_LOCK_RD);
   endfunction

endpackage

// File: rtl/spi_prog_sync.sv
module spi_prog_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [0:0] RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $fatal(1, "spi_prog_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= {W{RST_VAL}};
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter #(
   parameter int FRAME_BYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     active,
   input  logic                     sck_rise,
   input  logic                     sck_fall,
   input  logic                     mosi_s,
   input  logic                     tx_load,
   input  logic [7:0]               tx_byte,
   output logic                     byte_done,
   output logic [$clog2(FRAME_BYTES)-1:0] byte_idx,
   output logic [8*FRAME_BYTES-1:0] frame,
   output logic                     miso
);
   localparam int IDX_W = $clog2(FRAME_BYTES);
   localparam int CNT_W = IDX_W + 3;

   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       rx_q;
   logic [7:0]       tx_q;
   logic [7:0]       rx_next;

   assign rx_next = {rx_q[6:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         frame     <= '0;
         byte_done <= 1'b0;
         byte_idx  <= '0;
         miso      <= 1'b0;
      end else if (!active) begin
         bit_cnt   <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         byte_done <= 1'b0;
         miso      <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sck_rise) begin
            rx_q    <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt[2:0] == 3'd7) begin
               frame[{bit_cnt[CNT_W-1:3], 3'b000} +: 8] <= rx_next;
               byte_done <= 1'b1;
               byte_idx  <= bit_cnt[CNT_W-1:3];
            end
         end
         if (sck_fall) miso <= tx_q[7];
         if (tx_load) tx_q <= tx_byte;
         else if (sck_fall) tx_q <= {tx_q[6:0], 1'b0};
      end
   end
endmodule

// File: rtl/spi_prog_decode.sv
module spi_prog_decode
   import spi_prog_pkg::*;
#(
   parameter int PM_ADDR_W = 9,
   parameter int PM_PAGE_W = 4,
   parameter int EE_ADDR_W = 6,
   parameter int EE_PAGE_W = 2,
   parameter int LOCK_W    = 6,
   parameter int ADDR_W    = 9
) (
   input  logic [7:0]        b0,
   input  logic [7:0]        b1,
   input  logic [7:0]        b2,
   input  logic [7:0]        b3,
   output logic [3:0]        op,
   output logic              hi,
   output logic              is_enable,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        data
);
   localparam logic [15:0] PM_M    = 16'((32'd1 << PM_ADDR_W) - 1);
   localparam logic [15:0] PM_PG_M = 16'((32'd1 << PM_PAGE_W) - 1);
   localparam logic [15:0] EE_M    = 16'((32'd1 << EE_ADDR_W) - 1);
   localparam logic [15:0] EE_PG_M = 16'((32'd1 << EE_PAGE_W) - 1);
   localparam logic [7:0]  LOCK_M  = 8'((32'd1 << LOCK_W) - 1);

   logic [15:0] a16;
   logic [15:0] pm_word;
   logic [15:0] b2w;

   assign pm_word = {b1, b2} & PM_M;
   assign b2w     = {8'h00, b2};

   always_comb begin
      op        = OP_NONE;
      hi        = 1'b0;
      is_enable = 1'b0;
      a16       = '0;
      data      = b3;
      if (b0 == HDR_SYS) begin
         if (b1 == KEY_ENABLE) begin
            is_enable = 1'b1;
         end else if (b1[7:5] == 3'b100) begin
            op = OP_ERASE;
         end else if (b1[7:5] == 3'b111 && (b3 | LOCK_M) == 8'hFF) begin
            op   = OP_LOCK_WR;
            data = b3 & LOCK_M;
         end
      end else if ({b0[7:4], b0[2:0]} == 7'b0010_000) begin
         op  = OP_PM_READ;
         hi  = b0[3];
         a16 = pm_word;
      end else if (b0 == 8'h4C) begin
         op  = OP_PM_WRITE;
         a16 = pm_word & ~PM_PG_M;
      end else if ({b0[7:4], b0[2:0]} == 7'b0100_000) begin
         op  = OP_PM_LOAD;
         hi  = b0[3];
         a16 = b2w & PM_PG_M;
      end else begin
         unique case (b0)
            8'hA0: begin op = OP_EE_READ;  a16 = b2w & EE_M;            end
            8'hC0: begin op = OP_EE_WRITE; a16 = b2w & EE_M;            end
            8'hC1: begin op = OP_EE_LOAD;  a16 = b2w & EE_PG_M;         end
            8'hC2: begin op = OP_EE_PGWR;  a16 = b2w & EE_M & ~EE_PG_M; end
            8'h58: begin op = OP_LOCK_RD;                               end
            default: ;
         endcase
      end
   end

   assign addr = a16[ADDR_W-1:0];
endmodule

// File: rtl/spi_prog_target.sv
module spi_prog_target
   import spi_prog_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PM_ADDR_W   = 9,
   parameter int PM_PAGE_W   = 4,
   parameter int EE_ADDR_W   = 6,
   parameter int EE_PAGE_W   = 2,
   parameter int LOCK_W      = 6,
   localparam int ADDR_W     = int'(max2(PM_ADDR_W, EE_ADDR_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_rst_n,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic              cmd_valid,
   output logic [3:0]        cmd_op,
   output logic              cmd_hi,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [7:0]        cmd_data,
   output logic              rd_req,
   output logic [3:0]        rd_op,
   output logic              rd_hi,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_busy
);
   localparam int         FRAME_BYTES = 4;
   localparam int         IDX_W       = $clog2(FRAME_BYTES);
   localparam logic [7:0] LOCK_FILL   = ~8'((32'd1 << LOCK_W) - 1);

   generate
      if (PM_ADDR_W > 16 || PM_ADDR_W <= PM_PAGE_W || PM_PAGE_W > 8 || PM_PAGE_W < 1) begin : g_chk_pm
         $fatal(1, "program memory address or page width out of range");
      end
      if (EE_ADDR_W > 8 || EE_ADDR_W <= EE_PAGE_W || EE_PAGE_W < 1) begin : g_chk_ee
         $fatal(1, "EEPROM address or page width out of range");
      end
      if (LOCK_W < 1 || LOCK_W > 7) begin : g_chk_lock
         $fatal(1, "lock width must leave marker bits in the data byte");
      end
   endgenerate

   logic [1:0] sd_raw, sd_s;
   logic       prst_s;
   logic       sck_s, mosi_s, sck_d;
   logic       active, sck_rise, sck_fall;

   assign sd_raw = {sck, mosi};

   spi_prog_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(1'b0)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d(sd_raw), .q(sd_s)
   );
   spi_prog_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) u_sync_rst (
      .clk(clk), .rst_n(rst_n), .d(prog_rst_n), .q(prst_s)
   );

   assign sck_s  = sd_s[1];
   assign mosi_s = sd_s[0];
   assign active = ~prst_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise = active & sck_s & ~sck_d;
   assign sck_fall = active & ~sck_s & sck_d;

   logic                          byte_done;
   logic [IDX_W-1:0]              byte_idx;
   logic [8*FRAME_BYTES-1:0]      frame;
   logic                          tx_load;
   logic [7:0]                    tx_byte;

   spi_prog_shifter #(.FRAME_BYTES(FRAME_BYTES)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(active),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
      .tx_load(tx_load), .tx_byte(tx_byte),
      .byte_done(byte_done), .byte_idx(byte_idx), .frame(frame), .miso(miso)
   );

   logic [3:0]        dec_op;
   logic              dec_hi, dec_en;
   logic [ADDR_W-1:0] dec_addr;
   logic [7:0]        dec_data;

   spi_prog_decode #(
      .PM_ADDR_W(PM_ADDR_W), .PM_PAGE_W(PM_PAGE_W),
      .EE_ADDR_W(EE_ADDR_W), .EE_PAGE_W(EE_PAGE_W),
      .LOCK_W(LOCK_W), .ADDR_W(ADDR_W)
   ) u_dec (
      .b0(frame[7:0]), .b1(frame[15:8]), .b2(frame[23:16]), .b3(frame[31:24]),
      .op(dec_op), .hi(dec_hi), .is_enable(dec_en), .addr(dec_addr), .data(dec_data)
   );

   logic en_q;
   logic rd_pend, rd_pend_lock;
   logic frame_end, addr_end;

   assign frame_end = byte_done && (byte_idx == IDX_W'(FRAME_BYTES-1));
   assign addr_end  = byte_done && (byte_idx == IDX_W'(FRAME_BYTES-2));

   assign rd_req  = active && addr_end && en_q && is_read_op(dec_op);
   assign rd_op   = dec_op;
   assign rd_hi   = dec_hi;
   assign rd_addr = dec_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q         <= 1'b0;
         cmd_valid    <= 1'b0;
         cmd_op       <= OP_NONE;
         cmd_hi       <= 1'b0;
         cmd_addr     <= '0;
         cmd_data     <= '0;
         rd_pend      <= 1'b0;
         rd_pend_lock <= 1'b0;
      end else if (!active) begin
         en_q      <= 1'b0;
         cmd_valid <= 1'b0;
         rd_pend   <= 1'b0;
      end else begin
         cmd_valid    <= 1'b0;
         rd_pend      <= rd_req;
         rd_pend_lock <= (dec_op == OP_LOCK_RD);
         if (frame_end) begin
            if (dec_en) begin
               en_q <= 1'b1;
            end else if (en_q && is_strobe_op(dec_op) && !mem_busy) begin
               cmd_valid <= 1'b1;
               cmd_op    <= dec_op;
               cmd_hi    <= dec_hi;
               cmd_addr  <= dec_addr;
               cmd_data  <= dec_data;
            end
         end
      end
   end

   assign tx_load = rd_pend || (byte_done && !rd_req);
   assign tx_byte = rd_pend ? (rd_pend_lock ? (mem_rdata | LOCK_FILL) : mem_rdata)
                            : frame[{byte_idx, 3'b000} +: 8];
endmodule

// File: rtl/spi_prog_target_chk.sv
module spi_prog_target_chk (
   input logic clk,
   input logic rst_n,
   input logic active,
   input logic sck_rise,
   input logic sck_fall,
   input logic tx_load,
   input logic en_q,
   input logic cmd_valid,
   input logic rd_req,
   input logic mem_busy,
   input logic miso
);
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   a_r9_read_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   a_r4_cmd_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(en_q));

   a_r10_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !$past(mem_busy));

   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active) |-> (!cmd_valid && !rd_req && !miso));

   a_r2_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (miso != $past(miso)) |-> ($past(sck_fall) || !$past(active)));

   a_r9_load_clear_of_fall: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> !sck_fall);

   a_r1_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> !sck_fall);
endmodule

bind spi_prog_target spi_prog_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .active(active),
   .sck_rise(sck_rise), .sck_fall(sck_fall), .tx_load(tx_load),
   .en_q(en_q), .cmd_valid(cmd_valid), .rd_req(rd_req),
   .mem_busy(mem_busy), .miso(miso)
);

// File: tb/tb_spi_prog_target.sv
module tb_spi_prog_target;
   localparam int AW   = 9;
   localparam int HALF = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prog_rst_n = 1'b1;
   logic sck = 1'b0, mosi = 1'b0;
   logic miso;
   logic cmd_valid, cmd_hi, rd_req, rd_hi;
   logic [3:0] cmd_op, rd_op;
   logic [AW-1:0] cmd_addr, rd_addr;
   logic [7:0] cmd_data;
   logic [7:0] mem_rdata = 8'h00;
   logic mem_busy = 1'b0;

   always #2 clk = ~clk;

   spi_prog_target dut (
      .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
      .miso(miso), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_hi(cmd_hi),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_req(rd_req), .rd_op(rd_op),
      .rd_hi(rd_hi), .rd_addr(rd_addr), .mem_rdata(mem_rdata), .mem_busy(mem_busy)
   );

   int checks = 0, fails = 0;
   int cmd_cnt = 0, rd_cnt = 0, wide_cnt = 0, miso_glitch = 0;
   logic prev_cv = 1'b0;
   logic [3:0] l_op, l_rop;
   logic l_hi, l_rhi;
   logic [AW-1:0] l_addr, l_raddr;
   logic [7:0] l_data;
   bit en_exp = 0;

   function automatic logic [7:0] model(input logic [3:0] op, input logic h, input logic [AW-1:0] a);
      return 8'(a * 7'd37) ^ {h, 3'b101, op};
   endfunction

   always @(posedge clk) begin
      if (rd_req) mem_rdata <= model(rd_op, rd_hi, rd_addr);
      if (cmd_valid) begin
         cmd_cnt <= cmd_cnt + 1;
         l_op <= cmd_op; l_hi <= cmd_hi; l_addr <= cmd_addr; l_data <= cmd_data;
      end
      if (rd_req) begin
         rd_cnt <= rd_cnt + 1;
         l_rop <= rd_op; l_rhi <= rd_hi; l_raddr <= rd_addr;
      end
      if (cmd_valid && prev_cv) wide_cnt <= wide_cnt + 1;
      prev_cv <= cmd_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbits(input logic [31:0] w, input int from, input int n, output logic [31:0] got);
      got = '0;
      for (int i = from; i > from - n; i--) begin
         @(negedge clk) mosi = w[i];
         repeat (HALF - 1) @(negedge clk);
         got[i] = miso;
         sck = 1'b1;
         repeat (2) @(negedge clk);
         if (miso != got[i]) miso_glitch++;
         repeat (HALF - 2) @(negedge clk);
         if (miso != got[i]) miso_glitch++;
         sck = 1'b0;
      end
      repeat (8) @(negedge clk);
   endtask

   function automatic void ref_dec(input logic [7:0] c0, c1, c2, c3, output logic [3:0] op,
                                   output logic h, output logic [AW-1:0] a, output logic [7:0] d);
      op = 0; h = 0; a = 0; d = c3;
      case (c0)
         8'hAC: if (c1[7:5] == 3'b100) op = 1;
                else if (c1[7:5] == 3'b111 && c3[7:6] == 2'b11) begin op = 7; d = {2'b00, c3[5:0]}; end
         8'h20, 8'h28: begin op = 8; h = c0[3]; a = {c1[0], c2}; end
         8'h40, 8'h48: begin op = 2; h = c0[3]; a = AW'(c2[3:0]); end
         8'h4C: begin op = 3; a = {c1[0], c2[7:4], 4'b0}; end
         8'hA0: begin op = 9; a = AW'(c2[5:0]); end
         8'hC0: begin op = 4; a = AW'(c2[5:0]); end
         8'hC1: begin op = 5; a = AW'(c2[1:0]); end
         8'hC2: begin op = 6; a = AW'({c2[5:2], 2'b00}); end
         8'h58: op = 10;
         default: ;
      endcase
   endfunction

   function automatic string tag(input logic [3:0] op);
      case (op)
         1, 7: return "R6";
         2, 3, 8: return "R7";
         4, 5, 6, 9: return "R8";
         10: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic frame(input logic [7:0] c0, c1, c2, c3);
      logic [3:0] op; logic h; logic [AW-1:0] a; logic [7:0] d; logic [31:0] got;
      int cc, rc; bit busy_now;
      ref_dec(c0, c1, c2, c3, op, h, a, d);
      cc = cmd_cnt; rc = rd_cnt; busy_now = mem_busy;
      xbits({c0, c1, c2, c3}, 31, 32, got);
      chk(got[15:8] == c1, "R3 echo", got[15:8], c1);
      if (!en_exp) begin
         chk(cmd_cnt == cc && rd_cnt == rc, "R4 before enable", cmd_cnt - cc + rd_cnt - rc, 0);
      end else if (op >= 1 && op <= 7) begin
         if (busy_now) chk(cmd_cnt == cc, "R10 busy drop", cmd_cnt - cc, 0);
         else begin
            chk(cmd_cnt == cc + 1, tag(op), cmd_cnt - cc, 1);
            chk(l_op == op && l_addr == a && l_data == d && (op != 2 || l_hi == h),
                tag(op), {l_op, l_hi, l_addr, l_data}, {op, h, a, d});
         end
      end else if (op >= 8) begin
         chk(rd_cnt == rc + 1 && l_rop == op && l_raddr == a && l_rhi == h,
             busy_now ? "R10 read under busy" : tag(op), {l_rop, l_rhi, l_raddr}, {op, h, a});
         chk(got[7:0] == (model(op, h, a) | (op == 10 ? 8'hC0 : 8'h00)), "R9 read data",
             got[7:0], model(op, h, a) | (op == 10 ? 8'hC0 : 8'h00));
      end else begin
         chk(cmd_cnt == cc && rd_cnt == rc, tag(op), cmd_cnt - cc + rd_cnt - rc, 0);
      end
      if (op < 8) chk(got[7:0] == c2, "R3 echo byte3", got[7:0], c2);
   endtask

   task automatic enable();
      frame(8'hAC, 8'h53, 8'h00, 8'h00);
      en_exp = 1;
   endtask

   initial begin
      logic [31:0] g;
      int cc;
      void'($urandom(32'h1357));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(miso == 0 && cmd_valid == 0 && rd_req == 0, "R5 reset state", miso, 0);
      prog_rst_n = 1'b0;
      repeat (6) @(negedge clk);
      frame(8'hAC, 8'h80, 8'h00, 8'h00);          // R4: erase ignored
      frame(8'h20, 8'h01, 8'h33, 8'h00);          // R4: read ignored
      enable();
      // R1: nothing before the last bit
      cc = cmd_cnt;
      xbits({8'hAC, 8'h80, 8'h12, 8'h34}, 31, 31, g);
      chk(cmd_cnt == cc, "R1 early", cmd_cnt - cc, 0);
      xbits({8'hAC, 8'h80, 8'h12, 8'h34}, 0, 1, g);
      chk(cmd_cnt == cc + 1 && l_op == 1, "R1 completes", l_op, 1);
      frame(8'hAC, 8'hE0, 8'h00, 8'h15);          // R6 lock write
      frame(8'hAC, 8'hE0, 8'h00, 8'h95);          // R6 bad marker bits
      frame(8'h58, 8'h00, 8'h00, 8'h00);          // R9 lock read
      frame(8'h77, 8'h12, 8'h34, 8'h56);          // R11 unknown
      frame(8'h4C, 8'h01, 8'hFF, 8'h00);          // R7 page write top address
      // R10: busy across completion
      mem_busy = 1'b1;
      frame(8'h40, 8'h00, 8'h05, 8'hA5);
      frame(8'h28, 8'h01, 8'h80, 8'h00);
      mem_busy = 1'b0;
      // R5: programming reset mid-frame
      xbits({8'hC0, 8'h00, 8'h11, 8'h22}, 31, 12, g);
      prog_rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(miso == 0, "R5 miso idle", miso, 0);
      prog_rst_n = 1'b0;
      en_exp = 0;
      repeat (6) @(negedge clk);
      frame(8'hAC, 8'h80, 8'h00, 8'h00);          // R5 enable lost
      enable();
      frame(8'hC0, 8'h00, 8'h3F, 8'h99);          // R1 realigned
      for (int k = 0; k < 60; k++) begin
         logic [7:0] c0, c1, c2, c3;
         int sel;
         sel = $urandom_range(0, 12);
         c1 = 8'($urandom); c2 = 8'($urandom); c3 = 8'($urandom);
         case (sel)
            0: begin c0 = 8'hAC; c1 = {3'b100, c1[4:0]}; end
            1: begin c0 = 8'hAC; c1 = {3'b111, c1[4:0]}; if ($urandom_range(0, 2) != 0) c3[7:6] = 2'b11; end
            2: c0 = 8'h20;  3: c0 = 8'h28;  4: c0 = 8'h40;  5: c0 = 8'h48;
            6: c0 = 8'h4C;  7: c0 = 8'hA0;  8: c0 = 8'hC0;  9: c0 = 8'hC1;
            10: c0 = 8'hC2; 11: c0 = 8'h58;
            default: c0 = 8'($urandom);
         endcase
         if (c0 == 8'hAC && c1 == 8'h53) c1 = 8'h80;
         mem_busy = ($urandom_range(0, 3) == 0);
         frame(c0, c1, c2, c3);
      end
      mem_busy = 1'b0;
      chk(wide_cnt == 0, "R12 strobe width", wide_cnt, 0);
      chk(miso_glitch == 0, "R2 miso stable while high", miso_glitch, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule